// File: doc/BRIEF.md
# SD Data Transfer Stop Sequencer

This block decides how an SD host brings a data transfer to an end. A command sequence begins with a one-cycle start pulse. With that pulse come the command index, the response-type code, a multi-block flag and a read/write direction. From these the block classifies the sequence as single-block or multi-block. During a multi-block sequence it counts completed blocks against a programmed block count. It raises a stop-command (CMD12) request when the count is reached, provided automatic stopping is armed. It also raises that request when software pulses a stop. The request stays high until the command path acknowledges it.

Single-block sequences never produce CMD12. A software stop ends them with an access-end pulse. For a write, that pulse waits until the data buffer has drained and the card has left its busy state. A communication error or a timeout aborts the sequence silently, and no stop command can follow it. The count register is written only while no sequence is running.

Top module: `sd_stop_seq`

## Requirements
- R1: A sequence is multi-block when rsp_type is 3'b000 and cmd_idx is 18 or 25, or when rsp_type is 3'b011 to 3'b111 and multi_flag is 1. Every other combination is single-block.
- R2: Automatic stopping is armed only while cnt_en is 1, stop_sel is 2'b00 and the stored count is not zero.
- R3: In an armed multi-block sequence, cmd12_req rises in the cycle after the blk_done pulse that completes block N, where N is the stored count. It stays low after every earlier block.
- R4: A count write (cnt_wr_en) is ignored while a sequence is running. It takes effect when no sequence is running. The stored count resets to zero.
- R5: A stored count of zero blocks automatic stopping. A software stop still produces CMD12.
- R6: A stop_req pulse during a multi-block sequence raises cmd12_req in the next cycle. cmd12_req stays high until cmd12_ack. The cycle after the ack has acc_end high for one cycle and cmd12_req low.
- R7: An err or tmo pulse during a sequence ends it. After that, no cmd12_req or acc_end comes from later stop_req, blk_done, buf_empty or card_busy activity until a new start.
- R8: A stop_req during a single-block read gives a one-cycle acc_end in the next cycle and never raises cmd12_req.
- R9: A stop_req during a single-block write gives acc_end in the next cycle if buf_empty is 1. Otherwise acc_end comes in the cycle after the first cycle with buf_empty 1 and card_busy 0. cmd12_req never rises.
- R10: The block counter clears at each sequence start and saturates at all ones instead of wrapping.
- R11: After reset, cmd12_req and acc_end are 0 and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Block count write strobe |
| cnt_wr_data | input | CNT_W | Block count write value |
| cnt_en | input | 1 | Block count enable for automatic stop |
| stop_sel | input | SEL_W | Automatic stop select; 0 arms automatic stop |
| seq_start | input | 1 | Start of a command sequence (pulse) |
| cmd_idx | input | 6 | Command index of the starting sequence |
| rsp_type | input | 3 | Response-type code of the starting sequence |
| multi_flag | input | 1 | Multi-block transfer flag |
| is_write | input | 1 | 1 for a write sequence, 0 for a read |
| blk_done | input | 1 | One block transferred (pulse) |
| stop_req | input | 1 | Software stop request (pulse) |
| buf_empty | input | 1 | Data buffer holds no data |
| card_busy | input | 1 | Card signals busy |
| err | input | 1 | Communication error (pulse) |
| tmo | input | 1 | Timeout (pulse) |
| cmd12_ack | input | 1 | Command path accepted the stop command |
| cmd12_req | output | 1 | Request to issue CMD12 |
| acc_end | output | 1 | Access-end pulse |

## Verification
The hardest case to reach from the ports is counter saturation. Saturation only shows when the count would otherwise wrap back onto the stored limit. The bench stores the largest count of its narrow 4-bit configuration and keeps automatic stopping disarmed through select 01 while it sends 20 blocks. It then arms stopping and sends 20 more blocks. A wrapping counter would reach the limit again and raise cmd12_req, while a saturating one stays silent. The decode rule is swept over all response types, four command indices and both flag values, and the automatic stop is swept over every legal count.

// File: rtl/sd_stop_pkg.sv
package sd_stop_pkg;
  localparam int CMD_W = 6;
  localparam int RSP_W = 3;
  localparam logic [CMD_W-1:0] CMD_RD_MULTI = 6'd18;
  localparam logic [CMD_W-1:0] CMD_WR_MULTI = 6'd25;
  localparam logic [RSP_W-1:0] RSP_NONE     = 3'b000;
  localparam logic [RSP_W-1:0] RSP_FLAGGED  = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_STOP  = 2'd3
  } seq_state_t;

  function automatic logic is_multi(input logic [CMD_W-1:0] cmd,
                                    input logic [RSP_W-1:0] rsp,
                                    input logic             flag);
    logic by_cmd;
    logic by_flag;
    by_cmd  = (rsp == RSP_NONE) && ((cmd == CMD_RD_MULTI) || (cmd == CMD_WR_MULTI));
    by_flag = (rsp >= RSP_FLAGGED) && flag;
    return by_cmd || by_flag;
  endfunction
endpackage

// File: rtl/sd_blkcnt_reg.sv
module sd_blkcnt_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             busy,
  output logic [CNT_W-1:0] limit,
  output logic             limit_zero
);
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
    end else if (wr_en && !busy) begin
      limit_q <= wr_data;
    end
  end

  assign limit      = limit_q;
  assign limit_zero = (limit_q == '0);
endmodule

// File: rtl/sd_blk_counter.sv
module sd_blk_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_next[CNT_W-1:0];
    end
  end

  // The block now completing brings the count to the limit.
  assign hit   = (cnt_next == {1'b0, limit});
  assign count = cnt_q;
endmodule

// File: rtl/sd_stop_fsm.sv
module sd_stop_fsm
  import sd_stop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic seq_start,
  input  logic multi,
  input  logic is_write,
  input  logic stop_req,
  input  logic auto_fire,
  input  logic fault,
  input  logic buf_empty,
  input  logic card_busy,
  input  logic cmd12_ack,
  output logic cmd12_req,
  output logic acc_end,
  output logic busy,
  output logic start_ok,
  output logic running
);
  seq_state_t state_q, state_d;
  logic       multi_q, write_q;
  logic       req_q, req_d;
  logic       end_q, end_d;

  assign start_ok = (state_q == ST_IDLE) && seq_start;
  assign running  = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    end_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (seq_start) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (fault) begin
          state_d = ST_IDLE;
        end else if (multi_q) begin
          if (stop_req || auto_fire) begin
            state_d = ST_STOP;
            req_d   = 1'b1;
          end
        end else if (stop_req) begin
          if (!write_q || buf_empty) begin
            state_d = ST_IDLE;
            end_d   = 1'b1;
          end else begin
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (fault) begin
          state_d = ST_IDLE;
        end else if (buf_empty && !card_busy) begin
          state_d = ST_IDLE;
          end_d   = 1'b1;
        end
      end
      ST_STOP: begin
        if (cmd12_ack) begin
          state_d = ST_IDLE;
          req_d   = 1'b0;
          end_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      end_q   <= 1'b0;
      multi_q <= 1'b0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      end_q   <= end_d;
      if (start_ok) begin
        multi_q <= multi;
        write_q <= is_write;
      end
    end
  end

  assign cmd12_req = req_q;
  assign acc_end   = end_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/sd_stop_seq.sv
module sd_stop_seq
  import sd_stop_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] stop_sel,
  input  logic             seq_start,
  input  logic [5:0]       cmd_idx,
  input  logic [2:0]       rsp_type,
  input  logic             multi_flag,
  input  logic             is_write,
  input  logic             blk_done,
  input  logic             stop_req,
  input  logic             buf_empty,
  input  logic             card_busy,
  input  logic             err,
  input  logic             tmo,
  input  logic             cmd12_ack,
  output logic             cmd12_req,
  output logic             acc_end
);
  logic [CNT_W-1:0] cnt_limit;
  logic [CNT_W-1:0] blk_cnt;
  logic             limit_zero;
  logic             cnt_hit;
  logic             seq_busy;
  logic             start_ok;
  logic             running;
  logic             multi_dec;
  logic             auto_arm;
  logic             auto_fire;

  assign multi_dec = is_multi(cmd_idx, rsp_type, multi_flag);
  assign auto_arm  = cnt_en && (stop_sel == '0) && !limit_zero;
  assign auto_fire = auto_arm && blk_done && cnt_hit;

  sd_blkcnt_reg #(.CNT_W(CNT_W)) i_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cnt_wr_en),
    .wr_data    (cnt_wr_data),
    .busy       (seq_busy),
    .limit      (cnt_limit),
    .limit_zero (limit_zero)
  );

  sd_blk_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_ok),
    .inc   (blk_done && running),
    .limit (cnt_limit),
    .count (blk_cnt),
    .hit   (cnt_hit)
  );

  sd_stop_fsm i_fsm (
    .clk       (clk),
    .rst       (rst),
    .seq_start (seq_start),
    .multi     (multi_dec),
    .is_write  (is_write),
    .stop_req  (stop_req),
    .auto_fire (auto_fire),
    .fault     (err || tmo),
    .buf_empty (buf_empty),
    .card_busy (card_busy),
    .cmd12_ack (cmd12_ack),
    .cmd12_req (cmd12_req),
    .acc_end   (acc_end),
    .busy      (seq_busy),
    .start_ok  (start_ok),
    .running   (running)
  );
endmodule

// File: rtl/sd_stop_chk.sv
module sd_stop_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             seq_busy,
  input logic             seq_start,
  input logic             blk_done,
  input logic             cnt_wr_en,
  input logic             fault,
  input logic             cmd12_req,
  input logic             cmd12_ack,
  input logic             acc_end,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cnt_limit
);
  p_req_held_r6: assert property (@(posedge clk) disable iff (rst)
    cmd12_req && !cmd12_ack |=> cmd12_req);

  p_end_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    cmd12_req && cmd12_ack |=> acc_end && !cmd12_req);

  p_fault_silent_r7: assert property (@(posedge clk) disable iff (rst)
    seq_busy && !cmd12_req && fault |=> !cmd12_req && !acc_end);

  p_limit_locked_r4: assert property (@(posedge clk) disable iff (rst)
    seq_busy && cnt_wr_en |=> $stable(cnt_limit));

  p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_val == '1) && blk_done && !seq_start |=> cnt_val == '1);

  p_outputs_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_end, cmd12_req}));
endmodule

bind sd_stop_seq sd_stop_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .seq_busy  (seq_busy),
  .seq_start (seq_start),
  .blk_done  (blk_done),
  .cnt_wr_en (cnt_wr_en),
  .fault     (err || tmo),
  .cmd12_req (cmd12_req),
  .cmd12_ack (cmd12_ack),
  .acc_end   (acc_end),
  .cnt_val   (blk_cnt),
  .cnt_limit (cnt_limit)
);

// File: tb/test_sd_stop_seq.sv
module test_sd_stop_seq;
  localparam int CNT_W = 4;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_wr_en = 0;
  logic [CNT_W-1:0] cnt_wr_data = '0;
  logic cnt_en = 0;
  logic [SEL_W-1:0] stop_sel = '0;
  logic seq_start = 0;
  logic [5:0] cmd_idx = '0;
  logic [2:0] rsp_type = '0;
  logic multi_flag = 0, is_write = 0, blk_done = 0, stop_req = 0;
  logic buf_empty = 1, card_busy = 0, err = 0, tmo = 0, cmd12_ack = 0;
  logic cmd12_req, acc_end;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sd_stop_seq #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_sd_stop_seq (
    .clk(clk), .rst(rst), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_en(cnt_en), .stop_sel(stop_sel), .seq_start(seq_start),
    .cmd_idx(cmd_idx), .rsp_type(rsp_type), .multi_flag(multi_flag),
    .is_write(is_write), .blk_done(blk_done), .stop_req(stop_req),
    .buf_empty(buf_empty), .card_busy(card_busy), .err(err), .tmo(tmo),
    .cmd12_ack(cmd12_ack), .cmd12_req(cmd12_req), .acc_end(acc_end)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cnt(input int v);
    cnt_wr_en = 1; cnt_wr_data = CNT_W'(v); step(); cnt_wr_en = 0;
  endtask

  task automatic start(input int c, input int r, input logic f, input logic w);
    seq_start = 1; cmd_idx = 6'(c); rsp_type = 3'(r); multi_flag = f; is_write = w;
    step(); seq_start = 0;
  endtask

  task automatic blk();
    blk_done = 1; step(); blk_done = 0;
  endtask

  task automatic sw_stop();
    stop_req = 1; step(); stop_req = 0;
  endtask

  task automatic ack_and_end(input string tag);
    cmd12_ack = 1; step(); cmd12_ack = 0;
    chk(tag, acc_end, 1'b1);
    chk(tag, cmd12_req, 1'b0);
    step();
    chk(tag, acc_end, 1'b0);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step(); rst = 0; step();
    // R11: reset state
    chk("R11 cmd12_req after reset", cmd12_req, 1'b0);
    chk("R11 acc_end after reset", acc_end, 1'b0);
    // R4 / R11: count resets to zero, so automatic stop stays blocked
    cnt_en = 1; stop_sel = 2'b00;
    start(18, 0, 0, 0);
    for (int b = 0; b < 3; b++) begin blk(); chk("R4 reset count blocks auto", cmd12_req, 1'b0); end
    sw_stop(); chk("R5 software stop with zero count", cmd12_req, 1'b1);
    ack_and_end("R6 ack ends zero-count sequence");

    // R3: sweep every legal count, automatic stop on the last block
    for (int lim = 1; lim < 16; lim++) begin
      write_cnt(lim);
      start(25, 0, 0, 1);
      for (int b = 1; b <= lim; b++) begin
        blk();
        chk($sformatf("R3 count=%0d block=%0d", lim, b), cmd12_req, b == lim);
      end
      ack_and_end("R3 end after automatic stop");
    end

    // R2: disarmed by cnt_en=0 and by stop_sel=01
    write_cnt(2);
    cnt_en = 0;
    start(18, 0, 0, 0);
    for (int b = 0; b < 4; b++) begin blk(); chk("R2 cnt_en=0 no auto", cmd12_req, 1'b0); end
    sw_stop(); ack_and_end("R2 end");
    cnt_en = 1; stop_sel = 2'b01;
    start(18, 0, 0, 0);
    for (int b = 0; b < 4; b++) begin blk(); chk("R2 stop_sel=01 no auto", cmd12_req, 1'b0); end
    sw_stop(); ack_and_end("R2 end");
    stop_sel = 2'b00;

    // R4: write during a sequence ignored
    write_cnt(3);
    start(18, 0, 0, 0);
    write_cnt(5);
    blk(); blk(); chk("R4 block 2 no stop", cmd12_req, 1'b0);
    blk(); chk("R4 stop at old count 3", cmd12_req, 1'b1);
    ack_and_end("R4 end");
    start(18, 0, 0, 0);
    for (int b = 1; b <= 3; b++) begin blk(); chk("R4 write kept, count 3", cmd12_req, b == 3); end
    ack_and_end("R4 end");

    // R6: software stop held until ack
    cnt_en = 0;
    start(4, 5, 1, 1);
    blk(); blk();
    sw_stop(); chk("R6 request after stop", cmd12_req, 1'b1);
    for (int i = 0; i < 3; i++) begin step(); chk("R6 request held", cmd12_req, 1'b1); end
    ack_and_end("R6 acc_end after ack");

    // R7: error in a multi-block sequence
    cnt_en = 1; write_cnt(2);
    start(18, 0, 0, 0);
    blk();
    err = 1; step(); err = 0;
    chk("R7 no request after error", cmd12_req, 1'b0);
    blk(); blk(); sw_stop();
    chk("R7 no request later", cmd12_req, 1'b0);
    chk("R7 no acc_end later", acc_end, 1'b0);
    // R7: timeout while a single write drains
    buf_empty = 0; card_busy = 1;
    start(24, 1, 0, 1);
    sw_stop(); chk("R9 waits while buffer full", acc_end, 1'b0);
    tmo = 1; step(); tmo = 0;
    buf_empty = 1; card_busy = 0; step(); step();
    chk("R7 no acc_end after timeout", acc_end, 1'b0);
    chk("R7 no request after timeout", cmd12_req, 1'b0);

    // R8: single read
    start(17, 1, 0, 0);
    sw_stop();
    chk("R8 acc_end at once", acc_end, 1'b1);
    chk("R8 no request", cmd12_req, 1'b0);
    step(); chk("R8 acc_end one cycle", acc_end, 1'b0);

    // R9: single write, empty buffer then full buffer
    start(24, 1, 0, 1);
    sw_stop(); chk("R9 empty buffer ends at once", acc_end, 1'b1);
    step();
    buf_empty = 0; card_busy = 0;
    start(24, 1, 0, 1);
    sw_stop(); chk("R9 full buffer waits", acc_end, 1'b0);
    step(); card_busy = 1; step(); chk("R9 waits", acc_end, 1'b0);
    buf_empty = 1; step(); step(); chk("R9 waits on busy", acc_end, 1'b0);
    card_busy = 0; step(); chk("R9 acc_end after release", acc_end, 1'b1);
    chk("R9 no request", cmd12_req, 1'b0);
    step(); chk("R9 acc_end one cycle", acc_end, 1'b0);

    // R10: saturation and clearing
    write_cnt(15); stop_sel = 2'b01;
    start(18, 0, 0, 0);
    for (int b = 0; b < 20; b++) blk();
    stop_sel = 2'b00;
    for (int b = 0; b < 20; b++) begin blk(); chk("R10 saturated, no wrap hit", cmd12_req, 1'b0); end
    sw_stop(); ack_and_end("R10 end");
    start(18, 0, 0, 0);
    for (int b = 1; b <= 15; b++) begin blk(); chk("R10 cleared at start", cmd12_req, b == 15); end
    ack_and_end("R10 end");

    // R1: decode sweep
    cnt_en = 0;
    for (int r = 0; r < 8; r++) begin
      for (int ci = 0; ci < 4; ci++) begin
        for (int f = 0; f < 2; f++) begin
          int c;
          logic e;
          c = (ci == 0) ? 17 : (ci == 1) ? 18 : (ci == 2) ? 24 : 25;
          e = ((r == 0) && (c == 18 || c == 25)) || ((r >= 3) && (f == 1));
          start(c, r, f[0], 1'b0);
          sw_stop();
          chk($sformatf("R1 rsp=%0d cmd=%0d flag=%0d req", r, c, f), cmd12_req, e);
          chk($sformatf("R1 rsp=%0d cmd=%0d flag=%0d end", r, c, f), acc_end, !e);
          if (e) ack_and_end("R1 end");
          else step();
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule